// File: doc/BRIEF.md
# Programmable Output Bit Crossbar

This block forms one 32-bit output word on each instruction step. Every output bit has its own 7-bit source select, so a step carries 224 bits of selects. Each select picks one bit out of a 128-bit source space. The space holds a 64-bit input history, two 16-bit counters, an optional lookup-table result word, thirty counter-against-output comparison flags, the constants 0 and 1, and the word that was produced last. Three per-step flags change what the middle bank means and how selects are offset: counter bank, table overlay and relative addressing.

A sequencer outside the block supplies the selects, the flags, the counters and the table word. It also supplies a 2-bit read code and a 2-bit write code for each step. The read code sets how many fresh input bits shift into the history. The write code sets whether the new word is registered and how wide it is announced to be. The history always keeps the oldest unconsumed bit at position 0. The block has no state machine: its only state is the history register and the output register, and both advance only on an accepted step.

Top module: `bit_crossbar`

## Requirements
- R1: After reset, out_word is 0, out_valid is 0, out_bits is 0 and the whole history is 0.
- R2: Select values 0 to 31 return history bits 0 to 31. History bit 0 is the oldest unconsumed input bit.
- R3: Select values 32 to 63 return history bits 32 to 63 when ctr_bank is 0. When ctr_bank is 1, values 32 to 47 return cnt_a bits 0 to 15 and values 48 to 63 return cnt_b bits 0 to 15.
- R4: When lut_bank is 1, lut_word bit k replaces select value 32+base+k. The base is 24 for lut_wcode 0 (8-bit table), 16 for code 1 (16-bit table), and 0 for codes 2 and 3 (32-bit table). Values below 32+base keep their R3 meaning.
- R5: Select values 64 to 93 return comparison flags against the previous output word. The flags come in groups of three, in the order less-or-equal, greater, equal. Values 64 to 75 compare cnt_b[7:0] with output bytes at offsets 0, 8, 16 and 24. Values 76 to 87 do the same for cnt_b[15:8]. Values 88 to 93 compare all of cnt_b with output halves at offsets 0 and 16.
- R6: Select value 94 returns 0 and value 95 returns 1. A bit the program leaves unassigned is coded as 94.
- R7: Select values 96 to 127 return bits 0 to 31 of the previous out_word.
- R8: When rel_mode is 1, a select below 64 is replaced by (select + cnt_a) modulo 64. Selects of 64 and above are never offset.
- R9: On a step, read codes 1, 2 and 3 shift 8, 16 and 32 low bits of in_word into the top of the history, and the history moves down by the same amount. Code 0 leaves the history unchanged. A write in the same step uses the history as it was before the shift.
- R10: On a step with write code 1, 2 or 3, the selected word is registered into out_word on the next edge. out_valid is then 1 for one cycle and out_bits is 8, 16 or 32. With write code 0, out_word holds, out_valid is 0 and out_bits is 0.
- R11: While step_valid is 0, the history and out_word do not change and out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_valid | input | 1 | Apply the present instruction fields this cycle |
| sel_flat | input | 224 | 32 source selects of 7 bits; output bit g uses bits [7g+6:7g] |
| rd_code | input | 2 | Read size code (0, 8, 16, 32 bits) |
| wr_code | input | 2 | Write size code (0, 8, 16, 32 bits) |
| rel_mode | input | 1 | Offset low selects by cnt_a |
| ctr_bank | input | 1 | Middle bank shows counters instead of upper history |
| lut_bank | input | 1 | Table word overlays the middle bank |
| lut_wcode | input | 2 | Table width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cnt_a | input | 16 | Counter A |
| cnt_b | input | 16 | Counter B |
| lut_word | input | 32 | Table result word |
| in_word | input | 32 | Fresh input bits, low bits first |
| out_word | output | 32 | Last produced word |
| out_valid | output | 1 | One-cycle pulse after a writing step |
| out_bits | output | 6 | Width announced with the pulse |

## Verification
A read and a write can fall in the same step, and the built word must then come from the history as it stood before the shift. The bench provokes this with a step that reads 8 bits and writes 32 bits under identity selects. It judges the result by comparing out_word against the old low history word, then checks on a later identity write that the shift did take place. A second overlap feeds the previous output back through the comparison flags and the feedback bank in the same step that replaces it. The expected words are taken from the bench's record of the prior output.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SEL_W    = 7;
    localparam int unsigned CNT_W    = 16;
    localparam int unsigned HIST_W   = 2 * WORD_W;
    localparam int unsigned SPACE_W  = 1 << SEL_W;
    localparam int unsigned NFLAG    = 30;
    localparam int unsigned SELS_W   = WORD_W * SEL_W;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_8    = 2'd1,
        SZ_16   = 2'd2,
        SZ_32   = 2'd3
    } size_code_e;

    function automatic logic [5:0] size_bits(input logic [1:0] code);
        unique case (size_code_e'(code))
            SZ_NONE: size_bits = 6'd0;
            SZ_8:    size_bits = 6'd8;
            SZ_16:   size_bits = 6'd16;
            SZ_32:   size_bits = 6'd32;
        endcase
    endfunction

    function automatic logic [5:0] lut_base(input logic [1:0] wcode);
        unique case (wcode)
            2'd0:    lut_base = 6'd24;
            2'd1:    lut_base = 6'd16;
            default: lut_base = 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/bx_history.sv
module bx_history
    import bx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [1:0]        rd_code,
    input  logic [WORD_W-1:0] in_word,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            unique case (size_code_e'(rd_code))
                SZ_NONE: hist_q <= hist_q;
                SZ_8:    hist_q <= {in_word[7:0],  hist_q[HIST_W-1:8]};
                SZ_16:   hist_q <= {in_word[15:0], hist_q[HIST_W-1:16]};
                SZ_32:   hist_q <= {in_word,       hist_q[HIST_W-1:WORD_W]};
            endcase
        end
    end

    assign hist = hist_q;

    // R11 / R9: no accepted read, no movement
    p_hist_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && rd_code != 2'd0) |=> $stable(hist_q));

    // R9: a full-word read places the new word on top and moves the old top down
    p_hist_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && rd_code == 2'd3) |=>
            (hist_q[HIST_W-1:WORD_W] == $past(in_word)) &&
            (hist_q[WORD_W-1:0] == $past(hist_q[HIST_W-1:WORD_W])));
endmodule

// File: rtl/bx_source_bus.sv
module bx_source_bus
    import bx_pkg::*;
(
    input  logic [HIST_W-1:0]  hist,
    input  logic [CNT_W-1:0]   cnt_a,
    input  logic [CNT_W-1:0]   cnt_b,
    input  logic [WORD_W-1:0]  lut_word,
    input  logic [WORD_W-1:0]  prev_out,
    input  logic               ctr_bank,
    input  logic               lut_bank,
    input  logic [1:0]         lut_wcode,
    output logic [SPACE_W-1:0] space
);
    logic [WORD_W-1:0] mid_bank;
    logic [WORD_W-1:0] ctr_word;
    logic [WORD_W-1:0] hist_hi;
    logic [NFLAG-1:0]  flags;
    logic [5:0]        base;

    assign ctr_word = {cnt_b, cnt_a};
    assign hist_hi  = hist[HIST_W-1:WORD_W];
    assign base     = lut_base(lut_wcode);

    always_comb begin
        for (int i = 0; i < int'(WORD_W); i++) begin
            if (lut_bank && (6'(i) >= base)) begin
                mid_bank[i] = lut_word[5'(6'(i) - base)];
            end else if (ctr_bank) begin
                mid_bank[i] = ctr_word[5'(i)];
            end else begin
                mid_bank[i] = hist_hi[5'(i)];
            end
        end
    end

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_byte_cmp
            assign flags[3*k]      = cnt_b[7:0]  <= prev_out[8*k +: 8];
            assign flags[3*k+1]    = cnt_b[7:0]  >  prev_out[8*k +: 8];
            assign flags[3*k+2]    = cnt_b[7:0]  == prev_out[8*k +: 8];
            assign flags[12+3*k]   = cnt_b[15:8] <= prev_out[8*k +: 8];
            assign flags[12+3*k+1] = cnt_b[15:8] >  prev_out[8*k +: 8];
            assign flags[12+3*k+2] = cnt_b[15:8] == prev_out[8*k +: 8];
        end
        for (k = 0; k < 2; k++) begin : g_half_cmp
            assign flags[24+3*k]   = cnt_b <= prev_out[16*k +: 16];
            assign flags[24+3*k+1] = cnt_b >  prev_out[16*k +: 16];
            assign flags[24+3*k+2] = cnt_b == prev_out[16*k +: 16];
        end
    endgenerate

    assign space = {prev_out, 1'b1, 1'b0, flags, mid_bank, hist[WORD_W-1:0]};
endmodule

// File: rtl/bx_bit_pick.sv
module bx_bit_pick
    import bx_pkg::*;
(
    input  logic [SPACE_W-1:0] space,
    input  logic [SEL_W-1:0]   sel,
    input  logic               rel_mode,
    input  logic [SEL_W-2:0]   rel_ofs,
    output logic               bit_out
);
    logic [SEL_W-1:0] eff;

    always_comb begin
        if (rel_mode && !sel[SEL_W-1]) begin
            eff = {1'b0, sel[SEL_W-2:0] + rel_ofs};
        end else begin
            eff = sel;
        end
    end

    assign bit_out = space[eff];
endmodule

// File: rtl/bit_crossbar.sv
module bit_crossbar
    import bx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [SELS_W-1:0] sel_flat,
    input  logic [1:0]        rd_code,
    input  logic [1:0]        wr_code,
    input  logic              rel_mode,
    input  logic              ctr_bank,
    input  logic              lut_bank,
    input  logic [1:0]        lut_wcode,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic [WORD_W-1:0] lut_word,
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic [5:0]        out_bits
);
    logic [HIST_W-1:0]  hist;
    logic [SPACE_W-1:0] space;
    logic [WORD_W-1:0]  built;
    logic [WORD_W-1:0]  out_q;
    logic               valid_q;
    logic [5:0]         bits_q;
    logic               do_write;

    assign do_write = step_valid && (wr_code != 2'd0);

    bx_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (step_valid),
        .rd_code  (rd_code),
        .in_word  (in_word),
        .hist     (hist)
    );

    bx_source_bus u_bus (
        .hist      (hist),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b),
        .lut_word  (lut_word),
        .prev_out  (out_q),
        .ctr_bank  (ctr_bank),
        .lut_bank  (lut_bank),
        .lut_wcode (lut_wcode),
        .space     (space)
    );

    genvar g;
    generate
        for (g = 0; g < int'(WORD_W); g++) begin : g_pick
            bx_bit_pick u_pick (
                .space    (space),
                .sel      (sel_flat[g*SEL_W +: SEL_W]),
                .rel_mode (rel_mode),
                .rel_ofs  (cnt_a[SEL_W-2:0]),
                .bit_out  (built[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            valid_q <= 1'b0;
            bits_q  <= '0;
        end else begin
            valid_q <= do_write;
            bits_q  <= do_write ? size_bits(wr_code) : 6'd0;
            if (do_write) begin
                out_q <= built;
            end
        end
    end

    assign out_word  = out_q;
    assign out_valid = valid_q;
    assign out_bits  = bits_q;

    // R10: a writing step raises the pulse on the next edge
    p_pulse_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> out_valid);

    // R10 / R11: without a write the word holds and no pulse appears
    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !do_write |=> (!out_valid && $stable(out_word)));

    // R10: a pulse always carries a nonzero width, and a width only comes with a pulse
    p_width_with_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (out_bits != 6'd0));
endmodule

// File: tb/bit_crossbar_tb_top.sv
module bit_crossbar_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_valid = 1'b0;
    logic [223:0] sel_flat = '0;
    logic [1:0]   rd_code = '0;
    logic [1:0]   wr_code = '0;
    logic         rel_mode = 1'b0;
    logic         ctr_bank = 1'b0;
    logic         lut_bank = 1'b0;
    logic [1:0]   lut_wcode = '0;
    logic [15:0]  cnt_a = '0;
    logic [15:0]  cnt_b = '0;
    logic [31:0]  lut_word = '0;
    logic [31:0]  in_word = '0;
    logic [31:0]  out_word;
    logic         out_valid;
    logic [5:0]   out_bits;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [6:0]  s [32];
    logic [63:0] m_hist = '0;
    logic [31:0] m_prev = '0;

    localparam logic [31:0] WA = 32'hA5C3_0F81;
    localparam logic [31:0] WB = 32'h1234_5678;
    localparam logic [31:0] WL = 32'hCAFE_D00D;

    bit_crossbar dut_i (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .sel_flat(sel_flat),
        .rd_code(rd_code), .wr_code(wr_code), .rel_mode(rel_mode),
        .ctr_bank(ctr_bank), .lut_bank(lut_bank), .lut_wcode(lut_wcode),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .lut_word(lut_word), .in_word(in_word),
        .out_word(out_word), .out_valid(out_valid), .out_bits(out_bits)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pack_sel();
        for (int g = 0; g < 32; g++) sel_flat[g*7 +: 7] = s[g];
    endtask

    task automatic flags(input logic rel, input logic ctr, input logic lut, input logic [1:0] w);
        rel_mode = rel; ctr_bank = ctr; lut_bank = lut; lut_wcode = w;
    endtask

    // one accepted step; returns at the next falling edge with outputs settled
    task automatic step(input logic [1:0] rd, input logic [1:0] wr, input logic [31:0] din);
        @(negedge clk);
        pack_sel();
        rd_code = rd; wr_code = wr; in_word = din; step_valid = 1'b1;
        @(negedge clk);
        step_valid = 1'b0;
        unique case (rd)
            2'd1: m_hist = {din[7:0],  m_hist[63:8]};
            2'd2: m_hist = {din[15:0], m_hist[63:16]};
            2'd3: m_hist = {din,       m_hist[63:32]};
            default: ;
        endcase
    endtask

    task automatic sel_ident();
        for (int i = 0; i < 32; i++) s[i] = 7'(i);
    endtask

    function automatic logic [31:0] bitrev(input logic [31:0] v);
        for (int i = 0; i < 32; i++) bitrev[i] = v[31-i];
    endfunction

    function automatic logic [31:0] cmp_exp(input logic [31:0] p, input logic [15:0] cb);
        logic [31:0] e;
        for (int k = 0; k < 4; k++) begin
            e[3*k]      = cb[7:0]  <= p[8*k +: 8];
            e[3*k+1]    = cb[7:0]  >  p[8*k +: 8];
            e[3*k+2]    = cb[7:0]  == p[8*k +: 8];
            e[12+3*k]   = cb[15:8] <= p[8*k +: 8];
            e[12+3*k+1] = cb[15:8] >  p[8*k +: 8];
            e[12+3*k+2] = cb[15:8] == p[8*k +: 8];
        end
        for (int k = 0; k < 2; k++) begin
            e[24+3*k]   = cb <= p[16*k +: 16];
            e[24+3*k+1] = cb >  p[16*k +: 16];
            e[24+3*k+2] = cb == p[16*k +: 16];
        end
        e[30] = 1'b0;
        e[31] = 1'b1;
        return e;
    endfunction

    task automatic t_reset();
        check("R1 out_word", out_word, 32'h0);
        check("R1 out_valid", {31'b0, out_valid}, 32'h0);
        check("R1 out_bits", {26'b0, out_bits}, 32'h0);
        flags(0, 0, 0, 0);
        for (int i = 0; i < 32; i++) s[i] = 7'(i % 2 == 0 ? i / 2 : 32 + i / 2);
        step(2'd0, 2'd3, 32'h0);
        check("R1 history zero", out_word, 32'h0);
        m_prev = 32'h0;
    endtask

    task automatic t_load();
        flags(0, 0, 0, 0);
        sel_ident();
        step(2'd3, 2'd0, WA);
        check("R10 no write no pulse", {31'b0, out_valid}, 32'h0);
        step(2'd3, 2'd0, WB);
        check("R10 word held", out_word, m_prev);
        check("R10 bits zero", {26'b0, out_bits}, 32'h0);
    endtask

    task automatic t_identity();
        sel_ident();
        step(2'd0, 2'd3, 32'h0);
        check("R2 identity low bank", out_word, WA);
        check("R10 pulse", {31'b0, out_valid}, 32'h1);
        check("R10 width 32", {26'b0, out_bits}, 32'd32);
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, out_valid}, 32'h0);
        for (int i = 0; i < 32; i++) s[i] = 7'(31 - i);
        step(2'd0, 2'd2, 32'h0);
        check("R2 reversed", out_word, bitrev(WA));
        check("R10 width 16", {26'b0, out_bits}, 32'd16);
        step(2'd0, 2'd1, 32'h0);
        check("R10 width 8", {26'b0, out_bits}, 32'd8);
    endtask

    task automatic t_bank();
        for (int i = 0; i < 32; i++) s[i] = 7'(32 + i);
        flags(0, 0, 0, 0);
        step(2'd0, 2'd3, 32'h0);
        check("R3 upper history", out_word, WB);
        cnt_a = 16'hBEEF; cnt_b = 16'h0C0D;
        flags(0, 1, 0, 0);
        step(2'd0, 2'd3, 32'h0);
        check("R3 counter bank", out_word, {16'h0C0D, 16'hBEEF});
    endtask

    task automatic t_lut();
        lut_word = WL;
        for (int i = 0; i < 32; i++) s[i] = 7'(32 + i);
        flags(0, 0, 1, 2'd0);
        step(2'd0, 2'd3, 32'h0);
        check("R4 8-bit table base 24", out_word, {WL[7:0], WB[23:0]});
        flags(0, 1, 1, 2'd1);
        step(2'd0, 2'd3, 32'h0);
        check("R4 16-bit table base 16", out_word, {WL[15:0], 16'hBEEF});
        flags(0, 0, 1, 2'd2);
        step(2'd0, 2'd3, 32'h0);
        check("R4 32-bit table", out_word, WL);
        flags(0, 0, 0, 0);
    endtask

    task automatic t_const();
        for (int i = 0; i < 32; i++) s[i] = 7'd95;
        step(2'd0, 2'd3, 32'h0);
        check("R6 constant one", out_word, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) s[i] = 7'd94;
        step(2'd0, 2'd3, 32'h0);
        check("R6 constant zero", out_word, 32'h0);
    endtask

    task automatic t_feedback();
        sel_ident();
        step(2'd0, 2'd3, 32'h0);
        m_prev = out_word;
        for (int i = 0; i < 32; i++) s[i] = 7'(96 + (i + 8) % 32);
        step(2'd0, 2'd3, 32'h0);
        check("R7 feedback rotate", out_word, {m_prev[7:0], m_prev[31:8]});
        m_prev = out_word;
    endtask

    task automatic t_compare();
        sel_ident();
        step(2'd0, 2'd3, 32'h0);
        m_prev = out_word;
        cnt_b = 16'hC30F;
        for (int i = 0; i < 30; i++) s[i] = 7'(64 + i);
        s[30] = 7'd94; s[31] = 7'd95;
        step(2'd0, 2'd3, 32'h0);
        check("R5 compare flags set 1", out_word, cmp_exp(m_prev, 16'hC30F));
        m_prev = out_word;
        cnt_b = 16'h0081;
        step(2'd0, 2'd3, 32'h0);
        check("R5 compare flags set 2", out_word, cmp_exp(m_prev, 16'h0081));
        m_prev = out_word;
    endtask

    task automatic t_relative();
        logic [31:0] e;
        sel_ident();
        cnt_a = 16'd40;
        flags(1, 0, 0, 0);
        step(2'd0, 2'd3, 32'h0);
        for (int i = 0; i < 32; i++) e[i] = m_hist[(i + 40) % 64];
        check("R8 relative wrap", out_word, e);
        for (int i = 0; i < 32; i++) s[i] = 7'd94;
        s[0] = 7'd95;
        cnt_a = 16'd1;
        step(2'd0, 2'd3, 32'h0);
        check("R8 high select not offset", out_word, 32'h1);
        flags(0, 0, 0, 0);
        m_prev = out_word;
    endtask

    task automatic t_same_step();
        logic [31:0] old_lo;
        old_lo = m_hist[31:0];
        sel_ident();
        step(2'd1, 2'd3, 32'h0000_00E7);
        check("R9 write sees pre-read history", out_word, old_lo);
        step(2'd0, 2'd3, 32'h0);
        check("R9 8-bit shift", out_word, m_hist[31:0]);
        step(2'd2, 2'd0, 32'h0000_9A4B);
        step(2'd0, 2'd3, 32'h0);
        check("R9 16-bit shift", out_word, m_hist[31:0]);
        for (int i = 0; i < 32; i++) s[i] = 7'(32 + i);
        step(2'd0, 2'd3, 32'h0);
        check("R9 16-bit shift upper", out_word, m_hist[63:32]);
        m_prev = out_word;
    endtask

    task automatic t_nostep();
        @(negedge clk);
        sel_ident();
        pack_sel();
        rd_code = 2'd3; wr_code = 2'd3; in_word = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R11 no pulse without step", {31'b0, out_valid}, 32'h0);
        check("R11 word held without step", out_word, m_prev);
        step(2'd0, 2'd3, 32'h0);
        check("R11 history held without step", out_word, m_hist[31:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 out_word in reset", out_word, 32'h0);
        rst_n = 1'b1;
        t_load();
        t_identity();
        t_bank();
        t_lut();
        t_const();
        t_feedback();
        t_compare();
        t_relative();
        t_same_step();
        t_nostep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule